// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface Adapter

This block connects an external microcontroller bus to a small internal register file and a byte-addressed buffer memory. The host pins are sampled into one register stage inside the block's clock domain. Every output is registered. A read drives the data lanes two clocks after the host's strobe is seen at the pins.

Two static selects set the bus flavour. `bus_style` picks between separate active-low read and write strobes, or one active-low data strobe with a direction line. `mux_n` picks between a plain address bus and a multiplexed bus, where the address travels on the low data lines and is caught by an address-latch-enable pulse. A timing select controls strobe filtering. In normal timing a strobe must last a minimum number of clocks before it counts. The fast timing accepts single-clock strobes, and only on the plain bus.

Register 1 is the window into the buffer. Each access moves one byte through the low lane, or two bytes through both lanes when wide mode is on. A lane swap option reverses the byte order of wide transfers. After every data access the buffer pointer moves forward by the number of bytes moved. An active-low indicator marks wide data-window accesses. An interrupt output and a DMA request output of selectable polarity complete the block.

Top module: `hbi_adapter`

## Requirements
- R1: After reset both output enables are low, `io16_n` and `intr_n` are high, `dreq` is low, and the control register (address 0) and pointer registers (addresses 2, 3) read 0.
- R2: With `bus_style`=0, a low pulse on `wr_dir_n` (with `cs_n` low) writes `dq_lo_in` to the addressed register when the strobe rises. While `rd_ds_n` is low with `cs_n` low, `dq_lo_oe` is high and `dq_lo_out` carries the addressed register.
- R3: With `bus_style`=1, `rd_ds_n` is the active-low data strobe and `wr_dir_n` gives the direction: low means write, high means read. Write and read behave as in R2.
- R4: While `cs_n` is high, strobes have no effect: no register changes and `dq_lo_oe` stays low.
- R5: With `mux_n`=0, the register address is taken from `dq_lo_in[2:0]` while `ale` is high. It is held until the next `ale` pulse, and `addr_in` is ignored.
- R6: Address 0 is control: bit0 wide mode, bit1 lane swap, bit2 DMA request active-low, bit3 interrupt enable, and bits 7:4 read 0. Addresses 2 and 3 hold pointer bits 7:0 and 8 (the other bits of address 3 read 0). Addresses 4 to 7 are 8-bit scratch registers.
- R7: With wide mode off, an access to address 1 moves the byte at the pointer on the low lane. The pointer then advances by 1.
- R8: With wide mode on, an access to address 1 moves the word at pointer bits 8:1. The even byte goes on the low lane and the odd byte on the high lane, `dq_hi_oe` is high during reads, and the pointer advances by 2. With wide mode off, `dq_hi_oe` never rises.
- R9: With wide mode and lane swap both on, the even byte travels on the high lane and the odd byte on the low lane, for both reads and writes.
- R10: `io16_n` is low only while `cs_n` is low, wide mode is on and the latched address is 1.
- R11: `dreq` equals the core request `dma_src` when control bit2 is 0, and its inverse when bit2 is 1, one clock later.
- R12: `intr_n` goes low one clock after `irq_src` is high while control bit3 is 1. Otherwise it is high.
- R13: In normal timing (`speed_sel`=1, or any multiplexed bus) a strobe shorter than NORM_MIN clocks (default 3) is ignored. In fast timing (`speed_sel`=0 on the plain bus) a one-clock strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_style | input | 1 | 0: separate read/write strobes, 1: data strobe plus direction |
| mux_n | input | 1 | 0: multiplexed address/data, 1: plain address bus |
| speed_sel | input | 1 | 0: fast timing (plain bus only), 1: normal timing |
| addr_in | input | 3 | Register address on the plain bus |
| ale | input | 1 | Address latch enable, multiplexed bus |
| cs_n | input | 1 | Chip select, active low |
| wr_dir_n | input | 1 | Write strobe (style 0) or direction, low means write (style 1) |
| rd_ds_n | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| dq_lo_in | input | 8 | Low data lane from host, also address on multiplexed bus |
| dq_lo_out | output | 8 | Low data lane to host |
| dq_lo_oe | output | 1 | Low lane output enable |
| dq_hi_in | input | 8 | High data lane from host |
| dq_hi_out | output | 8 | High data lane to host |
| dq_hi_oe | output | 1 | High lane output enable |
| io16_n | output | 1 | Wide data-window access indicator, active low |
| irq_src | input | 1 | Interrupt request from core |
| dma_src | input | 1 | DMA request from core |
| intr_n | output | 1 | Interrupt output, active low |
| dreq | output | 1 | DMA request, selectable polarity |

## Verification
The bench checks where the buffer pointer ends up after byte and word accesses. A design that steps by the wrong amount, or that advances on ignored strobes, reads the wrong bytes from then on. It writes on both bus flavours with `addr_in` set to a decoy value, and reads every lane with swap on and off. A latch that tracks `addr_in` or a swapper that reverses only reads shows up as wrong data. Strobes of one, two and three clocks in each timing mode expose an off-by-one pulse filter, and also fast timing wrongly allowed on the multiplexed bus. A read of a scratch register with wide mode on confirms that the high lane and the indicator stay idle outside the data window.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADR_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] ADR_DATA   = 3'd1;
  localparam logic [REG_AW-1:0] ADR_PTR_LO = 3'd2;
  localparam logic [REG_AW-1:0] ADR_PTR_HI = 3'd3;

  localparam int CTL_WIDE  = 0;
  localparam int CTL_SWAP  = 1;
  localparam int CTL_DQLOW = 2;
  localparam int CTL_IEN   = 3;
  localparam int CTL_W     = 4;

  localparam int CH_WR = 0;
  localparam int CH_RD = 1;
endpackage

// File: rtl/hbi_strobe_dec.sv
module hbi_strobe_dec
  import hbi_pkg::*;
#(
  parameter int NORM_MIN = 3,
  parameter int DW       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_style,
  input  logic              mux_n,
  input  logic              speed_sel,
  input  logic [REG_AW-1:0] addr_in,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              wr_dir_n,
  input  logic              rd_ds_n,
  input  logic [DW-1:0]     dq_lo_in,
  input  logic [DW-1:0]     dq_hi_in,
  output logic              mux_s,
  output logic              ale_s,
  output logic [REG_AW-1:0] addr_s,
  output logic [DW-1:0]     lo_s,
  output logic              cs_act,
  output logic              rd_act,
  output logic              wr_act,
  output logic              rd_done,
  output logic              wr_done,
  output logic [DW-1:0]     wr_lo,
  output logic [DW-1:0]     wr_hi
);
  localparam int CNT_W = $clog2(NORM_MIN + 1) + 1;
  localparam logic [CNT_W-1:0] MIN_NORM = CNT_W'(NORM_MIN);
  localparam logic [CNT_W-1:0] MIN_FAST = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic          style_s, speed_s, cs_s, wrp_s, rdp_s;
  logic [DW-1:0] hi_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      style_s <= 1'b0;
      mux_s   <= 1'b1;
      speed_s <= 1'b1;
      cs_s    <= 1'b1;
      wrp_s   <= 1'b1;
      rdp_s   <= 1'b1;
      ale_s   <= 1'b0;
      addr_s  <= '0;
      lo_s    <= '0;
      hi_s    <= '0;
    end else begin
      style_s <= bus_style;
      mux_s   <= mux_n;
      speed_s <= speed_sel;
      cs_s    <= cs_n;
      wrp_s   <= wr_dir_n;
      rdp_s   <= rd_ds_n;
      ale_s   <= ale;
      addr_s  <= addr_in;
      lo_s    <= dq_lo_in;
      hi_s    <= dq_hi_in;
    end
  end

  assign cs_act = ~cs_s;
  assign wr_act = cs_act & (style_s ? (~rdp_s & ~wrp_s) : ~wrp_s);
  assign rd_act = cs_act & (style_s ? (~rdp_s &  wrp_s) : ~rdp_s);

  logic             fast;
  logic [CNT_W-1:0] min_len;
  assign fast    = ~speed_s & mux_s;
  assign min_len = fast ? MIN_FAST : MIN_NORM;

  logic [1:0] act_v, done_v;
  assign act_v[CH_WR] = wr_act;
  assign act_v[CH_RD] = rd_act;

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic [CNT_W-1:0] len_q;
    always_ff @(posedge clk) begin
      if (rst)               len_q <= '0;
      else if (act_v[g])     len_q <= (len_q == CNT_MAX) ? len_q : len_q + 1'b1;
      else                   len_q <= '0;
    end
    assign done_v[g] = ~act_v[g] & (len_q >= min_len);
  end

  assign wr_done = done_v[CH_WR];
  assign rd_done = done_v[CH_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_lo <= '0;
      wr_hi <= '0;
    end else if (wr_act) begin
      wr_lo <= lo_s;
      wr_hi <= hi_s;
    end
  end
endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch
  import hbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mux_s,
  input  logic              ale_s,
  input  logic              busy,
  input  logic [REG_AW-1:0] addr_s,
  input  logic [REG_AW-1:0] mux_addr,
  output logic [REG_AW-1:0] acc_addr
);
  always_ff @(posedge clk) begin
    if (rst)            acc_addr <= '0;
    else if (!mux_s) begin
      if (ale_s)        acc_addr <= mux_addr;
    end else if (!busy) acc_addr <= addr_s;
  end
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs
  import hbi_pkg::*;
#(
  parameter int PTR_W = 9,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] acc_addr,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic [DW-1:0]     wr_lo,
  input  logic [DW-1:0]     wr_hi,
  output logic              w16_en,
  output logic              swap_en,
  output logic              dreq_low,
  output logic              int_en,
  output logic [DW-1:0]     rd_lo,
  output logic [DW-1:0]     rd_hi
);
  localparam int HI_W  = PTR_W - DW;
  localparam int WORDS = 1 << (PTR_W - 1);
  localparam int SCR_N = 4;

  logic [CTL_W-1:0] ctrl_q;
  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    scr_q [SCR_N];
  logic [PTR_W-1:0] step;
  logic             is_data;

  assign w16_en   = ctrl_q[CTL_WIDE];
  assign swap_en  = ctrl_q[CTL_SWAP];
  assign dreq_low = ctrl_q[CTL_DQLOW];
  assign int_en   = ctrl_q[CTL_IEN];
  assign is_data  = (acc_addr == ADR_DATA);
  assign step     = w16_en ? PTR_W'(2) : PTR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ptr_q  <= '0;
      for (int i = 0; i < SCR_N; i++) scr_q[i] <= '0;
    end else if (wr_done) begin
      case (acc_addr)
        ADR_CTRL:   ctrl_q <= wr_lo[CTL_W-1:0];
        ADR_DATA:   ptr_q  <= ptr_q + step;
        ADR_PTR_LO: ptr_q[DW-1:0] <= wr_lo;
        ADR_PTR_HI: ptr_q[PTR_W-1:DW] <= wr_lo[HI_W-1:0];
        default:    scr_q[acc_addr[1:0]] <= wr_lo;
      endcase
    end else if (rd_done && is_data) begin
      ptr_q <= ptr_q + step;
    end
  end

  // buffer memory, byte-lane writes, registered read
  logic [2*DW-1:0]  mem [WORDS];
  logic [2*DW-1:0]  rword;
  logic [PTR_W-2:0] widx;
  logic             we, we_ev, we_od;
  logic [DW-1:0]    ev_byte, od_byte;

  assign widx    = ptr_q[PTR_W-1:1];
  assign we      = wr_done & is_data;
  assign we_ev   = we & (w16_en | ~ptr_q[0]);
  assign we_od   = we & (w16_en |  ptr_q[0]);
  assign ev_byte = (w16_en & swap_en) ? wr_hi : wr_lo;
  assign od_byte = w16_en ? (swap_en ? wr_lo : wr_hi) : wr_lo;

  always_ff @(posedge clk) begin
    if (we_ev) mem[widx][DW-1:0]    <= ev_byte;
    if (we_od) mem[widx][2*DW-1:DW] <= od_byte;
    rword <= mem[widx];
  end

  logic [DW-1:0] ev_rd, od_rd, data_lo;
  assign ev_rd   = rword[DW-1:0];
  assign od_rd   = rword[2*DW-1:DW];
  assign data_lo = w16_en ? (swap_en ? od_rd : ev_rd) : (ptr_q[0] ? od_rd : ev_rd);

  always_comb begin
    rd_hi = '0;
    case (acc_addr)
      ADR_CTRL:   rd_lo = {{(DW-CTL_W){1'b0}}, ctrl_q};
      ADR_DATA: begin
        rd_lo = data_lo;
        if (w16_en) rd_hi = swap_en ? ev_rd : od_rd;
      end
      ADR_PTR_LO: rd_lo = ptr_q[DW-1:0];
      ADR_PTR_HI: rd_lo = {{(2*DW-PTR_W){1'b0}}, ptr_q[PTR_W-1:DW]};
      default:    rd_lo = scr_q[acc_addr[1:0]];
    endcase
  end
endmodule

// File: rtl/hbi_bus_out.sv
module hbi_bus_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_act,
  input  logic          cs_act,
  input  logic          is_data,
  input  logic          w16_en,
  input  logic          int_en,
  input  logic          dreq_low,
  input  logic [DW-1:0] rd_lo,
  input  logic [DW-1:0] rd_hi,
  input  logic          irq_src,
  input  logic          dma_src,
  output logic [DW-1:0] dq_lo_out,
  output logic          dq_lo_oe,
  output logic [DW-1:0] dq_hi_out,
  output logic          dq_hi_oe,
  output logic          io16_n,
  output logic          intr_n,
  output logic          dreq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_lo_out <= '0;
      dq_hi_out <= '0;
      dq_lo_oe  <= 1'b0;
      dq_hi_oe  <= 1'b0;
      io16_n    <= 1'b1;
      intr_n    <= 1'b1;
      dreq      <= 1'b0;
    end else begin
      dq_lo_out <= rd_lo;
      dq_hi_out <= rd_hi;
      dq_lo_oe  <= rd_act;
      dq_hi_oe  <= rd_act & w16_en & is_data;
      io16_n    <= ~(cs_act & w16_en & is_data);
      intr_n    <= ~(irq_src & int_en);
      dreq      <= dma_src ^ dreq_low;
    end
  end
endmodule

// File: rtl/hbi_adapter.sv
module hbi_adapter
  import hbi_pkg::*;
#(
  parameter int NORM_MIN = 3,
  parameter int PTR_W    = 9,
  parameter int DW       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_style,
  input  logic              mux_n,
  input  logic              speed_sel,
  input  logic [REG_AW-1:0] addr_in,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              wr_dir_n,
  input  logic              rd_ds_n,
  input  logic [DW-1:0]     dq_lo_in,
  output logic [DW-1:0]     dq_lo_out,
  output logic              dq_lo_oe,
  input  logic [DW-1:0]     dq_hi_in,
  output logic [DW-1:0]     dq_hi_out,
  output logic              dq_hi_oe,
  output logic              io16_n,
  input  logic              irq_src,
  input  logic              dma_src,
  output logic              intr_n,
  output logic              dreq
);
  logic              mux_s, ale_s, cs_act, rd_act, wr_act, rd_done, wr_done;
  logic [REG_AW-1:0] addr_s, acc_addr;
  logic [DW-1:0]     lo_s, wr_lo, wr_hi, rd_lo, rd_hi;
  logic              w16_en, swap_en, dreq_low, int_en;

  hbi_strobe_dec #(.NORM_MIN(NORM_MIN), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .bus_style(bus_style), .mux_n(mux_n),
    .speed_sel(speed_sel), .addr_in(addr_in), .ale(ale), .cs_n(cs_n),
    .wr_dir_n(wr_dir_n), .rd_ds_n(rd_ds_n), .dq_lo_in(dq_lo_in),
    .dq_hi_in(dq_hi_in), .mux_s(mux_s), .ale_s(ale_s), .addr_s(addr_s),
    .lo_s(lo_s), .cs_act(cs_act), .rd_act(rd_act), .wr_act(wr_act),
    .rd_done(rd_done), .wr_done(wr_done), .wr_lo(wr_lo), .wr_hi(wr_hi)
  );

  hbi_addr_latch u_alat (
    .clk(clk), .rst(rst), .mux_s(mux_s), .ale_s(ale_s),
    .busy(rd_act | wr_act | rd_done | wr_done), .addr_s(addr_s),
    .mux_addr(lo_s[REG_AW-1:0]), .acc_addr(acc_addr)
  );

  hbi_regs #(.PTR_W(PTR_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .wr_done(wr_done),
    .rd_done(rd_done), .wr_lo(wr_lo), .wr_hi(wr_hi), .w16_en(w16_en),
    .swap_en(swap_en), .dreq_low(dreq_low), .int_en(int_en),
    .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  hbi_bus_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .rd_act(rd_act), .cs_act(cs_act),
    .is_data(acc_addr == ADR_DATA), .w16_en(w16_en), .int_en(int_en),
    .dreq_low(dreq_low), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .irq_src(irq_src), .dma_src(dma_src), .dq_lo_out(dq_lo_out),
    .dq_lo_oe(dq_lo_oe), .dq_hi_out(dq_hi_out), .dq_hi_oe(dq_hi_oe),
    .io16_n(io16_n), .intr_n(intr_n), .dreq(dreq)
  );
endmodule

// File: rtl/hbi_adapter_chk.sv
module hbi_adapter_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic dq_lo_oe,
  input logic dq_hi_oe,
  input logic io16_n,
  input logic intr_n,
  input logic dreq,
  input logic dma_src,
  input logic w16_en,
  input logic int_en,
  input logic dreq_low
);
  AST_CS_BLOCKS_OE: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n) && $past(cs_n, 2)) |-> !dq_lo_oe);                 // R4
  AST_HI_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !w16_en |-> !dq_hi_oe);                                          // R8
  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (rst)
    dq_hi_oe |-> dq_lo_oe);                                          // R8
  AST_IO16_NEEDS_WIDE: assert property (@(posedge clk) disable iff (rst)
    !io16_n |-> $past(w16_en));                                      // R10
  AST_INTR_GATED: assert property (@(posedge clk) disable iff (rst)
    !intr_n |-> $past(int_en));                                      // R12
  AST_DREQ_IDLE_HIGH_POL: assert property (@(posedge clk) disable iff (rst)
    (!$past(dreq_low) && !$past(dma_src)) |-> !dreq);                // R11
endmodule

bind hbi_adapter hbi_adapter_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .dq_lo_oe(dq_lo_oe),
  .dq_hi_oe(dq_hi_oe), .io16_n(io16_n), .intr_n(intr_n), .dreq(dreq),
  .dma_src(dma_src), .w16_en(w16_en), .int_en(int_en), .dreq_low(dreq_low)
);

// File: tb/tb_hbi_adapter.sv
module tb_hbi_adapter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_style = 1'b0, mux_n = 1'b1, speed_sel = 1'b1;
  logic [2:0] addr_in = '0;
  logic       ale = 1'b0, cs_n = 1'b1, wr_dir_n = 1'b1, rd_ds_n = 1'b1;
  logic [7:0] dq_lo_in = '0, dq_hi_in = '0;
  logic [7:0] dq_lo_out, dq_hi_out;
  logic       dq_lo_oe, dq_hi_oe, io16_n, intr_n, dreq;
  logic       irq_src = 1'b0, dma_src = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbi_adapter dut (
    .clk(clk), .rst(rst), .bus_style(bus_style), .mux_n(mux_n),
    .speed_sel(speed_sel), .addr_in(addr_in), .ale(ale), .cs_n(cs_n),
    .wr_dir_n(wr_dir_n), .rd_ds_n(rd_ds_n), .dq_lo_in(dq_lo_in),
    .dq_lo_out(dq_lo_out), .dq_lo_oe(dq_lo_oe), .dq_hi_in(dq_hi_in),
    .dq_hi_out(dq_hi_out), .dq_hi_oe(dq_hi_oe), .io16_n(io16_n),
    .irq_src(irq_src), .dma_src(dma_src), .intr_n(intr_n), .dreq(dreq)
  );

  typedef struct packed {
    logic       muxed;
    logic       style;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  // write then read back in the same bus flavour (R2 R3 R5 R6)
  localparam vec_t VECS [11] = '{
    '{1'b0, 1'b0, 3'd4, 8'hA5, 8'hA5},
    '{1'b0, 1'b1, 3'd5, 8'h3C, 8'h3C},
    '{1'b1, 1'b0, 3'd6, 8'h96, 8'h96},
    '{1'b1, 1'b1, 3'd7, 8'h0F, 8'h0F},
    '{1'b0, 1'b0, 3'd0, 8'hF8, 8'h08},
    '{1'b0, 1'b1, 3'd0, 8'h00, 8'h00},
    '{1'b0, 1'b0, 3'd2, 8'h5B, 8'h5B},
    '{1'b1, 1'b0, 3'd3, 8'hFF, 8'h01},
    '{1'b0, 1'b1, 3'd3, 8'h00, 8'h00},
    '{1'b1, 1'b1, 3'd4, 8'hC3, 8'hC3},
    '{1'b0, 1'b0, 3'd5, 8'h81, 8'h81}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_ale(input logic [2:0] a);
    @(negedge clk);
    dq_lo_in = {5'b0, a};
    ale = 1'b1;
    repeat (2) @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] lo, input logic [7:0] hi,
                        input int len, input logic use_cs);
    if (!mux_n) begin
      addr_in = ~a;
      do_ale(a);
    end else addr_in = a;
    @(negedge clk);
    cs_n = ~use_cs;
    dq_lo_in = lo;
    dq_hi_in = hi;
    wr_dir_n = 1'b0;
    if (bus_style) rd_ds_n = 1'b0;
    repeat (len) @(negedge clk);
    if (bus_style) rd_ds_n = 1'b1;
    else wr_dir_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    wr_dir_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic use_cs,
                        output logic [7:0] lo, output logic [7:0] hi,
                        output logic loe, output logic hoe, output logic i16);
    if (!mux_n) begin
      addr_in = ~a;
      do_ale(a);
    end else addr_in = a;
    @(negedge clk);
    cs_n = ~use_cs;
    wr_dir_n = 1'b1;
    rd_ds_n = 1'b0;
    repeat (5) @(negedge clk);
    lo = dq_lo_out; hi = dq_hi_out; loe = dq_lo_oe; hoe = dq_hi_oe; i16 = io16_n;
    @(negedge clk);
    rd_ds_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] rdv(input logic [2:0] a);
    return 8'h00;
  endfunction

  logic [7:0] lo, hi;
  logic       loe, hoe, i16;

  task automatic rd_lo(input logic [2:0] a, input string req, input logic [7:0] exp);
    bus_rd(a, 1'b1, lo, hi, loe, hoe, i16);
    chk(req, {8'h00, lo}, {8'h00, exp});
  endtask

  task automatic set_ptr(input logic [8:0] p);
    bus_wr(3'd2, p[7:0], 8'h00, 4, 1'b1);
    bus_wr(3'd3, {7'b0, p[8]}, 8'h00, 4, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 lo_oe", {15'b0, dq_lo_oe}, 16'h0);
    chk("R1 hi_oe", {15'b0, dq_hi_oe}, 16'h0);
    chk("R1 io16_n", {15'b0, io16_n}, 16'h1);
    chk("R1 intr_n", {15'b0, intr_n}, 16'h1);
    chk("R1 dreq", {15'b0, dreq}, 16'h0);
    rd_lo(3'd0, "R1 ctrl", 8'h00);
    rd_lo(3'd2, "R1 ptr_lo", 8'h00);
    rd_lo(3'd3, "R1 ptr_hi", 8'h00);

    // vector table: R2 R3 R5 R6
    for (int i = 0; i < 11; i++) begin
      mux_n = ~VECS[i].muxed;
      bus_style = VECS[i].style;
      bus_wr(VECS[i].addr, VECS[i].data, 8'h00, 4, 1'b1);
      bus_rd(VECS[i].addr, 1'b1, lo, hi, loe, hoe, i16);
      chk(VECS[i].style ? "R3 table data" : "R2 table data", {8'h0, lo}, {8'h0, VECS[i].exp});
      chk(VECS[i].style ? "R3 table oe" : "R2 table oe", {15'b0, loe}, 16'h1);
    end
    mux_n = 1'b1;
    bus_style = 1'b0;

    // R5: multiplexed address ignores addr_in
    bus_wr(3'd4, 8'h44, 8'h00, 4, 1'b1);
    mux_n = 1'b0;
    bus_wr(3'd6, 8'h66, 8'h00, 4, 1'b1);
    mux_n = 1'b1;
    rd_lo(3'd6, "R5 latched target", 8'h66);
    rd_lo(3'd4, "R5 decoy untouched", 8'h44);

    // R4: chip select high blocks access
    bus_wr(3'd7, 8'h77, 8'h00, 4, 1'b1);
    bus_wr(3'd7, 8'h70, 8'h00, 4, 1'b0);
    rd_lo(3'd7, "R4 write ignored", 8'h77);
    bus_rd(3'd7, 1'b0, lo, hi, loe, hoe, i16);
    chk("R4 no oe", {15'b0, loe}, 16'h0);

    // R13: strobe length filter
    bus_wr(3'd7, 8'h01, 8'h00, 1, 1'b1);
    rd_lo(3'd7, "R13 normal 1clk", 8'h77);
    bus_wr(3'd7, 8'h02, 8'h00, 2, 1'b1);
    rd_lo(3'd7, "R13 normal 2clk", 8'h77);
    bus_wr(3'd7, 8'h03, 8'h00, 3, 1'b1);
    rd_lo(3'd7, "R13 normal 3clk", 8'h03);
    speed_sel = 1'b0;
    bus_wr(3'd7, 8'h11, 8'h00, 1, 1'b1);
    rd_lo(3'd7, "R13 fast 1clk", 8'h11);
    mux_n = 1'b0;
    bus_wr(3'd7, 8'h22, 8'h00, 1, 1'b1);
    mux_n = 1'b1;
    speed_sel = 1'b1;
    rd_lo(3'd7, "R13 mux forces normal", 8'h11);

    // R7: byte window
    set_ptr(9'd0);
    bus_wr(3'd1, 8'h11, 8'h00, 4, 1'b1);
    bus_wr(3'd1, 8'h22, 8'h00, 4, 1'b1);
    bus_wr(3'd1, 8'h33, 8'h00, 4, 1'b1);
    rd_lo(3'd2, "R7 ptr after writes", 8'h03);
    set_ptr(9'd0);
    bus_rd(3'd1, 1'b1, lo, hi, loe, hoe, i16);
    chk("R7 byte0", {8'h0, lo}, 16'h0011);
    chk("R8 hi_oe off narrow", {15'b0, hoe}, 16'h0);
    chk("R10 io16 narrow", {15'b0, i16}, 16'h1);
    rd_lo(3'd1, "R7 byte1", 8'h22);
    rd_lo(3'd1, "R7 byte2", 8'h33);
    set_ptr(9'h100);
    rd_lo(3'd3, "R6 ptr bit8", 8'h01);
    rd_lo(3'd2, "R6 ptr lo", 8'h00);

    // R8 R10: wide window
    bus_wr(3'd0, 8'h01, 8'h00, 4, 1'b1);
    set_ptr(9'd0);
    bus_rd(3'd1, 1'b1, lo, hi, loe, hoe, i16);
    chk("R8 wide lo", {8'h0, lo}, 16'h0011);
    chk("R8 wide hi", {8'h0, hi}, 16'h0022);
    chk("R8 hi_oe", {15'b0, hoe}, 16'h1);
    chk("R10 io16 active", {15'b0, i16}, 16'h0);
    rd_lo(3'd2, "R8 ptr step 2", 8'h02);
    bus_wr(3'd1, 8'hAA, 8'hBB, 4, 1'b1);
    rd_lo(3'd2, "R8 ptr after wide write", 8'h04);
    bus_rd(3'd4, 1'b1, lo, hi, loe, hoe, i16);
    chk("R10 io16 scratch", {15'b0, i16}, 16'h1);
    chk("R8 hi_oe scratch", {15'b0, hoe}, 16'h0);

    // R9: lane swap
    bus_wr(3'd0, 8'h03, 8'h00, 4, 1'b1);
    set_ptr(9'd2);
    bus_rd(3'd1, 1'b1, lo, hi, loe, hoe, i16);
    chk("R9 swap read lo", {8'h0, lo}, 16'h00BB);
    chk("R9 swap read hi", {8'h0, hi}, 16'h00AA);
    bus_wr(3'd1, 8'hC1, 8'hC2, 4, 1'b1);
    bus_wr(3'd0, 8'h00, 8'h00, 4, 1'b1);
    set_ptr(9'd4);
    rd_lo(3'd1, "R9 swap write even", 8'hC2);
    rd_lo(3'd1, "R9 swap write odd", 8'hC1);
    set_ptr(9'd2);
    rd_lo(3'd1, "R8 wide write even", 8'hAA);
    rd_lo(3'd1, "R8 wide write odd", 8'hBB);

    // R11 R12: request outputs
    irq_src = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 masked", {15'b0, intr_n}, 16'h1);
    bus_wr(3'd0, 8'h08, 8'h00, 4, 1'b1);
    chk("R12 enabled", {15'b0, intr_n}, 16'h0);
    irq_src = 1'b0;
    @(negedge clk);
    chk("R12 released", {15'b0, intr_n}, 16'h1);
    dma_src = 1'b1;
    @(negedge clk);
    chk("R11 high pol", {15'b0, dreq}, 16'h1);
    bus_wr(3'd0, 8'h04, 8'h00, 4, 1'b1);
    chk("R11 low pol asserted", {15'b0, dreq}, 16'h0);
    dma_src = 1'b0;
    @(negedge clk);
    chk("R11 low pol idle", {15'b0, dreq}, 16'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule